// File: doc/BRIEF.md
# Thermostat Alert with Fault Queue

This block watches a stream of 13-bit signed temperature samples and drives one alert line. Each sample that arrives with the valid strobe is compared with a programmable high limit and a programmable low limit. A run of consecutive qualifying samples must build up before the alert changes state. The run length is programmable: 1, 2, 4 or 6 samples. This filter keeps single noisy readings from toggling the line.

Three alert behaviours are available:

- **Comparator.** The alert sets on high readings and drops on low readings, giving hysteresis.
- **Interrupt.** The alert is latched. It fires alternately on a high run and on a low run, and is cleared by a register read or by entry into shutdown.
- **Interrupt-comparator.** The alert sets like the comparator, but after the low run it is released only by a later communication with the device.

The polarity bit picks whether the active level is low or high. The output stands in for an open-drain pin driver. The surrounding serial interface supplies the read, communication and shutdown pulses, and the sensor supplies the samples.

Top module: `thermo_alert`

## Requirements
- R1: While reset is high, and on the first clock edge after it, `alert_out` is 1, which is inactive with the polarity bit at 0. Every mode starts with the alert inactive and watching for high samples.
- R2: `mode` selects the behaviour:
  - 2'b00 is comparator.
  - 2'b01 is interrupt.
  - 2'b10 is interrupt-comparator.
  - The reserved code 2'b11 behaves as comparator.
- R3: `fq_sel` sets the number of consecutive qualifying samples needed: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6. A valid sample that fails the condition being watched restarts the count from zero.
- R4: In comparator mode the alert becomes active after the required run of samples with `smp_temp >= lim_hi`. It becomes inactive after the required run of samples with `smp_temp < lim_lo`. Read, communication and shutdown pulses have no effect in this mode.
- R5: In interrupt mode the alert becomes active after the required run of high samples. It stays active, ignoring samples, until a read pulse or a shutdown pulse clears it. After that, only a run of low samples activates it again, and a read or shutdown clears it once more. The cycle then restarts with high samples.
- R6: In interrupt-comparator mode the alert becomes active as in comparator mode. After the required low run it stays active and ignores samples until a communication pulse arrives in a later cycle; that pulse releases it. A communication pulse before the low run completes has no effect.
- R7: With `pol` at 0 the active level of `alert_out` is 0; with `pol` at 1 it is 1. `alert_out` is registered and changes on the same clock edge that accepts the sample, pulse or mode change causing the transition.
- R8: All 13 bits of the sample and of both limits are compared as two's-complement signed values, down to the least significant bit.
- R9: A change of `mode` between consecutive cycles clears the run count and returns the alert to inactive, watching for high samples. The sample offered in that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | A new temperature sample is present this cycle |
| smp_temp | input | 13 | Signed temperature sample |
| lim_hi | input | 13 | Signed high limit (alert set threshold, inclusive) |
| lim_lo | input | 13 | Signed low limit (release threshold, exclusive) |
| mode | input | 2 | Alert behaviour select |
| fq_sel | input | 2 | Consecutive-sample run length select |
| pol | input | 1 | Active level of the alert output |
| rd_pulse | input | 1 | A register read completed |
| comm_pulse | input | 1 | A communication with the device occurred |
| sd_pulse | input | 1 | Shutdown was entered |
| alert_out | output | 1 | Registered alert level |

## Verification
Each mode is driven with sample runs that sit exactly on the high limit, one step below it, exactly on the low limit and one step below it. This separates the inclusive high test from the exclusive low test. Runs broken by a single non-qualifying sample at every run length show whether the count truly restarts rather than accumulating. Reads, communications and shutdowns are sent both where they must act and where they must be ignored: in comparator mode, before the low run in interrupt-comparator mode, and while the interrupt alert is latched. Negative limits and limits at the ends of the 13-bit range confirm that the comparison is signed.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  typedef enum logic [1:0] {
    MD_CMP  = 2'b00,
    MD_IRQ  = 2'b01,
    MD_ICMP = 2'b10,
    MD_RSV  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HOT    = 3'd1,
    ST_HOLD   = 3'd2,
    ST_IRQ_HI = 3'd3,
    ST_ARM_LO = 3'd4,
    ST_IRQ_LO = 3'd5
  } st_e;

  function automatic logic [2:0] run_need(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/thermo_cmp.sv
module thermo_cmp #(
  parameter int TW = 13
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] hi,
  input  logic [TW-1:0] lo,
  output logic          hi_hit,
  output logic          lo_hit
);
  always_comb begin
    hi_hit = $signed(temp) >= $signed(hi);
    lo_hit = $signed(temp) <  $signed(lo);
  end
endmodule

// File: rtl/thermo_fault_run.sv
module thermo_fault_run #(
  parameter int CW  = 3,
  parameter int SAT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic          cond,
  input  logic [CW-1:0] need,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] inc;

  always_comb begin
    inc  = cnt + CW'(1);
    done = vld && cond && !clr && (inc >= need);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (vld) begin
      if (!cond || done) cnt <= '0;
      else if (cnt != CW'(SAT)) cnt <= inc;
    end
  end
endmodule

// File: rtl/thermo_alert_fsm.sv
module thermo_alert_fsm
  import thermo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       done,
  input  logic       rd_pulse,
  input  logic       comm_pulse,
  input  logic       sd_pulse,
  output logic       chg,
  output logic       watching,
  output logic       watch_hi,
  output logic       act,
  output logic       act_nxt,
  output logic [1:0] mode_q
);
  st_e   st, st_n;
  mode_e md;

  always_comb begin
    md = (mode == MD_RSV) ? MD_CMP : mode_e'(mode);
    chg = (mode != mode_q);
    st_n = st;
    if (chg) begin
      st_n = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:   if (done) st_n = (md == MD_IRQ) ? ST_IRQ_HI : ST_HOT;
        ST_HOT:    if (done) st_n = (md == MD_ICMP) ? ST_HOLD : ST_IDLE;
        ST_HOLD:   if (comm_pulse) st_n = ST_IDLE;
        ST_IRQ_HI: if (rd_pulse || sd_pulse) st_n = ST_ARM_LO;
        ST_ARM_LO: if (done) st_n = ST_IRQ_LO;
        ST_IRQ_LO: if (rd_pulse || sd_pulse) st_n = ST_IDLE;
        default:   st_n = ST_IDLE;
      endcase
    end
  end

  function automatic logic is_active(input st_e s);
    return (s == ST_HOT) || (s == ST_HOLD) || (s == ST_IRQ_HI) || (s == ST_IRQ_LO);
  endfunction

  always_comb begin
    act      = is_active(st);
    act_nxt  = is_active(st_n);
    watching = (st == ST_IDLE) || (st == ST_HOT) || (st == ST_ARM_LO);
    watch_hi = (st == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      mode_q <= MD_CMP;
    end else begin
      st     <= st_n;
      mode_q <= mode;
    end
  end
endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
  import thermo_pkg::*;
#(
  parameter int TW = 13,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic [TW-1:0] smp_temp,
  input  logic [TW-1:0] lim_hi,
  input  logic [TW-1:0] lim_lo,
  input  logic [1:0]    mode,
  input  logic [1:0]    fq_sel,
  input  logic          pol,
  input  logic          rd_pulse,
  input  logic          comm_pulse,
  input  logic          sd_pulse,
  output logic          alert_out
);
  localparam int RUN_MAX = 6;

  logic          hi_hit, lo_hit, cond, done;
  logic          chg, watching, watch_hi, act, act_nxt;
  logic [1:0]    mode_q;
  logic [CW-1:0] need;

  thermo_cmp #(.TW(TW)) u_cmp (
    .temp(smp_temp), .hi(lim_hi), .lo(lim_lo),
    .hi_hit(hi_hit), .lo_hit(lo_hit)
  );

  always_comb begin
    cond = watch_hi ? hi_hit : lo_hit;
    need = CW'(run_need(fq_sel));
  end

  thermo_fault_run #(.CW(CW), .SAT(RUN_MAX)) u_run (
    .clk(clk), .rst(rst), .clr(chg || !watching),
    .vld(smp_vld), .cond(cond), .need(need), .done(done)
  );

  thermo_alert_fsm u_fsm (
    .clk(clk), .rst(rst), .mode(mode), .done(done),
    .rd_pulse(rd_pulse), .comm_pulse(comm_pulse), .sd_pulse(sd_pulse),
    .chg(chg), .watching(watching), .watch_hi(watch_hi),
    .act(act), .act_nxt(act_nxt), .mode_q(mode_q)
  );

  always_ff @(posedge clk) begin
    if (rst) alert_out <= 1'b1;
    else     alert_out <= pol ? act_nxt : !act_nxt;
  end
endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_vld,
  input logic       rd_pulse,
  input logic       comm_pulse,
  input logic       pol,
  input logic [1:0] mode,
  input logic [1:0] mode_q,
  input logic       act,
  input logic       alert_out
);
  // R4: comparator ignores reads and communications; only samples move it
  p_cmp_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && mode_q == 2'b00 && !smp_vld) |=> $stable(act));

  // R5: a read clears the latched interrupt alert
  p_irq_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && mode_q == 2'b01 && act && rd_pulse) |=> !act);

  // R6: without a sample or communication, an active alert holds
  p_icmp_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && mode_q == 2'b10 && act && !comm_pulse && !smp_vld) |=> act);

  // R7: output level follows state through the polarity bit
  p_polarity_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (alert_out == ($past(pol) ? act : !act)));

  // R3: no activation without a sample
  p_no_fire_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!act && !smp_vld) |=> !act);

  // R9: a mode change leaves the alert inactive
  p_mode_change_r9: assert property (@(posedge clk) disable iff (rst)
    (mode != mode_q) |=> !act);
endmodule

bind thermo_alert thermo_alert_chk u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .rd_pulse(rd_pulse),
  .comm_pulse(comm_pulse), .pol(pol), .mode(mode), .mode_q(mode_q),
  .act(act), .alert_out(alert_out)
);

// File: tb/thermo_alert_tb.sv
`timescale 1ns/1ps
module thermo_alert_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_vld = 1'b0;
  logic [12:0] smp_temp = '0;
  logic [12:0] lim_hi = 13'd1280;
  logic [12:0] lim_lo = 13'd1200;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  fq_sel = 2'b00;
  logic        pol = 1'b0;
  logic        rd_pulse = 1'b0, comm_pulse = 1'b0, sd_pulse = 1'b0;
  logic        alert_out;

  int checks = 0, fails = 0;
  int hi_i = 1280, lo_i = 1200, t_i = 0;

  // reference model state
  bit on, want_hi, wait_rd, wait_cm;
  int run, prev_mode;

  always #2.5 clk = ~clk;

  thermo_alert u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_temp(smp_temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .mode(mode), .fq_sel(fq_sel),
    .pol(pol), .rd_pulse(rd_pulse), .comm_pulse(comm_pulse),
    .sd_pulse(sd_pulse), .alert_out(alert_out)
  );

  function automatic int need_of(input int f);
    if (f == 0) return 1;
    if (f == 1) return 2;
    if (f == 2) return 4;
    return 6;
  endfunction

  task automatic model_tick();
    int m;
    bit hit;
    if (rst) begin
      on = 0; want_hi = 1; wait_rd = 0; wait_cm = 0; run = 0; prev_mode = 0;
      return;
    end
    m = (int'(mode) == 3) ? 0 : int'(mode);
    if (int'(mode) != prev_mode) begin
      on = 0; want_hi = 1; wait_rd = 0; wait_cm = 0; run = 0;
    end else if (wait_rd) begin
      if (rd_pulse || sd_pulse) begin on = 0; wait_rd = 0; end
    end else if (wait_cm) begin
      if (comm_pulse) begin on = 0; wait_cm = 0; want_hi = 1; end
    end else if (smp_vld) begin
      hit = want_hi ? (t_i >= hi_i) : (t_i < lo_i);
      if (!hit) run = 0;
      else begin
        run++;
        if (run >= need_of(int'(fq_sel))) begin
          run = 0;
          if (m == 1) begin
            on = 1; wait_rd = 1; want_hi = !want_hi;
          end else if (want_hi) begin
            on = 1; want_hi = 0;
          end else if (m == 2) begin
            wait_cm = 1;
          end else begin
            on = 0; want_hi = 1;
          end
        end
      end
    end
    prev_mode = int'(mode);
  endtask

  task automatic check(input string tag);
    logic expv;
    expv = rst ? 1'b1 : (pol ? on : !on);
    checks++;
    if (alert_out !== expv) begin
      fails++;
      $display("FAIL %s at %0t: alert_out=%b expected %b", tag, $time, alert_out, expv);
    end
  endtask

  task automatic step(input bit v, input int t, input bit r, input bit c,
                      input bit s, input string tag);
    smp_vld = v; t_i = t; smp_temp = 13'(t);
    rd_pulse = r; comm_pulse = c; sd_pulse = s;
    lim_hi = 13'(hi_i); lim_lo = 13'(lo_i);
    @(posedge clk);
    model_tick();
    @(negedge clk);
    check(tag);
  endtask

  task automatic samp(input int t, input string tag);
    step(1, t, 0, 0, 0, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_up();
  end

  initial begin
    // R1: reset state
    repeat (3) idle("R1");
    rst = 1'b0;
    idle("R1");

    // R4: comparator, single-sample run, inclusive high and exclusive low
    samp(1279, "R4"); samp(1280, "R4");
    step(0, 0, 1, 1, 1, "R4");
    samp(1250, "R4"); samp(1200, "R4"); samp(1199, "R4");
    step(0, 0, 1, 1, 1, "R4");

    // R3: run lengths with restarts
    fq_sel = 2'b01;
    samp(1280, "R3"); samp(1000, "R3"); samp(1280, "R3"); samp(1280, "R3");
    samp(1199, "R3"); samp(1250, "R3"); samp(1199, "R3"); samp(1199, "R3");
    fq_sel = 2'b10;
    repeat (3) samp(1300, "R3");
    samp(1279, "R3");
    repeat (4) samp(1300, "R3");
    repeat (4) samp(100, "R3");
    fq_sel = 2'b11;
    repeat (5) samp(1300, "R3");
    idle("R3");
    samp(0, "R3");
    repeat (6) samp(1300, "R3");
    repeat (5) samp(-50, "R3");
    samp(1200, "R3");
    repeat (6) samp(-50, "R3");
    fq_sel = 2'b00;

    // R2 / R9: reserved code acts as comparator; mode change drops alert
    mode = 2'b11;
    idle("R9"); samp(1300, "R2"); samp(1100, "R2"); samp(1300, "R2");
    mode = 2'b00;
    idle("R9"); samp(1000, "R9");

    // R5: interrupt mode
    mode = 2'b01;
    samp(1300, "R9");
    samp(1300, "R5"); samp(1000, "R5"); samp(1300, "R5");
    step(0, 0, 1, 0, 0, "R5");
    samp(1300, "R5"); samp(1300, "R5"); samp(1100, "R5");
    step(0, 0, 0, 1, 0, "R5"); samp(1300, "R5");
    step(0, 0, 0, 0, 1, "R5");
    fq_sel = 2'b01;
    samp(1100, "R5"); samp(1300, "R5"); samp(1300, "R5");
    step(0, 0, 1, 0, 0, "R5");
    samp(1100, "R5"); samp(1100, "R5");
    step(1, 1100, 1, 0, 0, "R5");
    fq_sel = 2'b00;

    // R6: interrupt-comparator mode
    mode = 2'b10;
    idle("R9");
    samp(1300, "R6");
    step(0, 0, 1, 1, 1, "R6");
    samp(1250, "R6");
    step(1, 1100, 0, 1, 0, "R6");
    samp(1300, "R6"); idle("R6");
    step(0, 0, 1, 0, 1, "R6");
    step(0, 0, 0, 1, 0, "R6");
    samp(1250, "R6"); samp(1280, "R6");
    samp(1000, "R6");
    step(1, 1300, 0, 1, 0, "R6");
    idle("R6");

    // R7: polarity
    mode = 2'b00;
    idle("R9");
    pol = 1'b1;
    idle("R7"); samp(1280, "R7"); idle("R7");
    pol = 1'b0;
    idle("R7"); samp(1199, "R7");
    pol = 1'b1;
    idle("R7");
    pol = 1'b0;

    // R8: signed 13-bit compare
    hi_i = -16; lo_i = -32;
    samp(-17, "R8"); samp(-16, "R8"); samp(-32, "R8"); samp(-33, "R8");
    samp(4095, "R8"); samp(-4096, "R8");
    hi_i = 4095; lo_i = -4095;
    samp(4094, "R8"); samp(4095, "R8"); samp(-4095, "R8"); samp(-4096, "R8");
    hi_i = -4096;
    samp(-4096, "R8");

    finish_up();
  end
endmodule